// File: doc/BRIEF.md
# Operate-Group Action Executor

This block carries out the register-action instruction of a 36-bit processor. The 12-bit action field is bit-coded, so one instruction can ask for several actions at once. The actions are: clear the AC, clear the IO, OR the console test-word switches into the AC, complement the AC, request a halt, and set or clear program flags. The block applies the requested actions in a fixed order, so the result of any mix of bits is well defined.

Upstream decode raises `valid_i` for one cycle and presents the field together with the current AC and IO values. The updated AC and IO, and the new state of the six program flags owned here, appear on the outputs at the first clock edge after the strobe. A halt request shows as a one-cycle pulse in that same cycle. Register updates that share the instruction with the halt still take effect.

Top module: `opr_exec`

## Requirements
- R1: Field bit 11 (octal 4000) gives `io_o` = 0. With bit 11 low, `io_o` takes `io_i`.
- R2: Field bit 10 (octal 2000) ORs `test_word_i` into the AC value.
- R3: Field bit 9 (octal 1000) inverts every AC bit, which is the ones'-complement negation. It is applied after the clear and after the test-word OR.
- R4: Field bit 7 (octal 200) clears the AC before the other AC actions. With bits 7 and 10 together, `ac_o` equals `test_word_i`. With bits 7 and 9 together, `ac_o` is all ones.
- R5: Field bit 8 (octal 400) raises `halt_o` for exactly the one cycle after the strobe. The AC, IO and flag updates of the same instruction still happen.
- R6: With bit 3 low, selector bits 2:0 = n, for n = 1..6, clear `flags_o[n-1]`. A selector of 7 clears all six flags.
- R7: With bit 3 high, selector n = 1..6 sets `flags_o[n-1]`. A selector of 7 sets all six flags.
- R8: A selector of 0 leaves `flags_o` unchanged, whatever the value of bit 3.
- R9: While `valid_i` is low, `ac_o`, `io_o` and `flags_o` hold their values and `halt_o` stays low.
- R10: After reset, `ac_o`, `io_o`, `flags_o` and `halt_o` are all zero.
- R11: Every result appears at the first rising clock edge after the cycle in which `valid_i` is high. Back-to-back strobes are accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction strobe |
| addr_i | input | 12 | Bit-coded action field |
| test_word_i | input | 36 | Console test-word switches |
| ac_i | input | 36 | Current AC value |
| io_i | input | 36 | Current IO value |
| ac_o | output | 36 | Updated AC |
| io_o | output | 36 | Updated IO |
| flags_o | output | 6 | Program flags |
| halt_o | output | 1 | One-cycle halt request |

## Verification
The hardest cases to reach are the combinations where ordering matters. Examples are clear followed by OR and then complement, and flag writes whose effect depends on flag state left by earlier instructions. Each of these also has to hold next to a halt in the same word. The bench reaches them by sweeping all 4096 field values twice, back to back, with data that changes every cycle. The flags are never reset between instructions, so every set and clear code is applied to many different earlier flag states. A model in the bench tracks the expected flag state.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int unsigned WORD_W  = 36;
  localparam int unsigned FLAG_N  = 6;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned FSEL_W  = 3;

  localparam int unsigned B_CLR_IO = 11;
  localparam int unsigned B_OR_TW  = 10;
  localparam int unsigned B_CMA    = 9;
  localparam int unsigned B_HALT   = 8;
  localparam int unsigned B_CLR_AC = 7;
  localparam int unsigned B_FSET   = 3;

  typedef struct packed {
    logic              clr_io;
    logic              or_tw;
    logic              cma;
    logic              halt;
    logic              clr_ac;
    logic              fset;
    logic [FSEL_W-1:0] fsel;
  } opr_cmd_t;

  function automatic opr_cmd_t decode(input logic [ADDR_W-1:0] a);
    opr_cmd_t c;
    c.clr_io = a[B_CLR_IO];
    c.or_tw  = a[B_OR_TW];
    c.cma    = a[B_CMA];
    c.halt   = a[B_HALT];
    c.clr_ac = a[B_CLR_AC];
    c.fset   = a[B_FSET];
    c.fsel   = a[FSEL_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/opr_reg_path.sv
module opr_reg_path
  import opr_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  opr_cmd_t       cmd_i,
  input  logic [W-1:0]   ac_i,
  input  logic [W-1:0]   io_i,
  input  logic [W-1:0]   tw_i,
  output logic [W-1:0]   ac_o,
  output logic [W-1:0]   io_o
);
  logic [W-1:0] ac_s1, ac_s2;

  // stage order fixed: clear, then OR, then complement
  always_comb begin
    ac_s1 = cmd_i.clr_ac ? '0 : ac_i;
    ac_s2 = cmd_i.or_tw ? (ac_s1 | tw_i) : ac_s1;
    ac_o  = cmd_i.cma ? ~ac_s2 : ac_s2;
    io_o  = cmd_i.clr_io ? '0 : io_i;
  end
endmodule

// File: rtl/opr_flag_unit.sv
module opr_flag_unit #(
  parameter int unsigned N     = 6,
  parameter int unsigned SEL_W = 3
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             set_i,
  input  logic [N-1:0]     flags_i,
  output logic [N-1:0]     flags_o
);
  localparam logic [SEL_W-1:0] SEL_ALL = {SEL_W{1'b1}};

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic hit;
    assign hit        = (sel_i == SEL_ALL) || (sel_i == SEL_W'(i + 1));
    assign flags_o[i] = hit ? set_i : flags_i[i];
  end
endmodule

// File: rtl/opr_exec.sv
module opr_exec
  import opr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [11:0]       addr_i,
  input  logic [35:0]       test_word_i,
  input  logic [35:0]       ac_i,
  input  logic [35:0]       io_i,
  output logic [35:0]       ac_o,
  output logic [35:0]       io_o,
  output logic [5:0]        flags_o,
  output logic              halt_o
);
  opr_cmd_t          cmd;
  logic [WORD_W-1:0] ac_n, io_n;
  logic [FLAG_N-1:0] flags_n;
  logic [WORD_W-1:0] ac_q, io_q;
  logic [FLAG_N-1:0] flags_q;
  logic              halt_q;

  assign cmd = decode(addr_i);

  opr_reg_path #(.W(WORD_W)) u_reg_path (
    .cmd_i (cmd),
    .ac_i  (ac_i),
    .io_i  (io_i),
    .tw_i  (test_word_i),
    .ac_o  (ac_n),
    .io_o  (io_n)
  );

  opr_flag_unit #(.N(FLAG_N), .SEL_W(FSEL_W)) u_flag_unit (
    .sel_i   (cmd.fsel),
    .set_i   (cmd.fset),
    .flags_i (flags_q),
    .flags_o (flags_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q    <= '0;
      io_q    <= '0;
      flags_q <= '0;
      halt_q  <= 1'b0;
    end else begin
      halt_q <= valid_i & cmd.halt;
      if (valid_i) begin
        ac_q    <= ac_n;
        io_q    <= io_n;
        flags_q <= flags_n;
      end
    end
  end

  assign ac_o    = ac_q;
  assign io_o    = io_q;
  assign flags_o = flags_q;
  assign halt_o  = halt_q;

  p_io_clear_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_i[B_CLR_IO]) |=> (io_o == '0));

  p_clear_then_or_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_i[B_CLR_AC] && addr_i[B_OR_TW] && !addr_i[B_CMA])
      |=> (ac_o == $past(test_word_i)));

  p_clear_then_cma_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_i[B_CLR_AC] && !addr_i[B_OR_TW] && addr_i[B_CMA])
      |=> (&ac_o));

  p_halt_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !halt_o);

  p_flag_sel0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_i[FSEL_W-1:0] == '0) |=> $stable(flags_o));

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(ac_o) && $stable(io_o) && $stable(flags_o)));

  p_set_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && addr_i[B_FSET] && addr_i[FSEL_W-1:0] == '1) |=> (&flags_o));

  p_clr_all_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !addr_i[B_FSET] && addr_i[FSEL_W-1:0] == '1) |=> (flags_o == '0));
endmodule

// File: tb/opr_exec_tb.sv
module opr_exec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [11:0] addr = '0;
  logic [35:0] tw = '0, ac = '0, io = '0;
  logic [35:0] ac_o, io_o;
  logic [5:0]  flags_o;
  logic        halt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [35:0] e_ac = '0, e_io = '0;
  logic [5:0]  e_fl = '0;
  logic        e_halt = 1'b0;

  always #2.5 clk = ~clk;

  opr_exec u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .addr_i(addr),
    .test_word_i(tw), .ac_i(ac), .io_i(io),
    .ac_o(ac_o), .io_o(io_o), .flags_o(flags_o), .halt_o(halt_o)
  );

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input logic [11:0] a);
    chk(a[11] ? "R1 io" : "R1 io pass", io_o, e_io);
    chk(a[7] ? "R4 ac" : (a[9] ? "R3 ac" : "R2 ac"), ac_o, e_ac);
    chk(a[3] ? "R7 flags" : ((a[2:0] == 0) ? "R8 flags" : "R6 flags"), 36'(flags_o), 36'(e_fl));
    chk("R5 halt", 36'(halt_o), 36'(e_halt));
  endtask

  // model of one instruction, computed from the requirements
  task automatic model(input logic [11:0] a, input logic [35:0] a_ac,
                       input logic [35:0] a_io, input logic [35:0] a_tw);
    logic [35:0] x;
    logic [5:0]  m;
    x = a_ac;
    if (a[7])  x = 36'd0;
    if (a[10]) x = x | a_tw;
    if (a[9])  x = ~x;
    e_ac = x;
    e_io = a[11] ? 36'd0 : a_io;
    if (a[2:0] == 3'd7)      m = 6'h3f;
    else if (a[2:0] == 3'd0) m = 6'h00;
    else                     m = 6'(1) << (a[2:0] - 3'd1);
    e_fl   = a[3] ? (e_fl | m) : (e_fl & ~m);
    e_halt = a[8];
  endtask

  initial begin
    logic [11:0] prev;
    prev = '0;
    #12;
    chk("R10 ac", ac_o, 36'd0);
    chk("R10 io", io_o, 36'd0);
    chk("R10 flags", 36'(flags_o), 36'd0);
    chk("R10 halt", 36'(halt_o), 36'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 4096; i++) begin
        @(negedge clk);
        if (pass != 0 || i != 0) check_all(prev);
        addr  = pass == 0 ? 12'(i) : 12'(4095 - i);
        ac    = 36'(i + pass * 7) * 36'h3_1415_9265;
        io    = ~ac ^ 36'h5_A5A5_A5A5;
        tw    = {ac[17:0], io[35:18]} ^ 36'(pass * 36'h0_0F0F_0F0F);
        valid = 1'b1;
        model(addr, ac, io, tw);
        prev  = addr;
      end
    end
    @(negedge clk);
    check_all(prev); // R11 last back-to-back result
    valid = 1'b0;
    // R9: inputs change with valid low; outputs must hold
    addr = 12'o7777; ac = 36'h1_2345_6789; io = 36'h0_ABCD_EF01; tw = '1;
    e_halt = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R9 ac", ac_o, e_ac);
      chk("R9 io", io_o, e_io);
      chk("R9 flags", 36'(flags_o), 36'(e_fl));
      chk("R9 halt", 36'(halt_o), 36'd0);
    end
    // R5: halt plus register updates, then halt drops
    valid = 1'b1; addr = 12'o4617; // clr io, halt, cla, set all flags
    model(addr, ac, io, tw);
    @(negedge clk); valid = 1'b0;
    chk("R5 halt pulse", 36'(halt_o), 36'd1);
    chk("R5 ac with halt", ac_o, 36'd0);
    chk("R5 flags with halt", 36'(flags_o), 36'h3f);
    @(negedge clk);
    chk("R5 halt one cycle", 36'(halt_o), 36'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule